// File: doc/BRIEF.md
# Oversampled Single-Bit Delta-Sigma Modulator

This block converts a PCM sample into a one-bit stream whose density of ones follows the sample value. It runs at the oversampled rate. A clock enable marks each oversampling step, and the sample is held constant for the whole period of that PCM word. A typical setup uses 64 steps per word, for example 3.072 MHz for 48 kHz audio. At each enabled step the block produces one output bit. A downstream low-pass or decimation stage averages these bits to recover the value.

Two input codings are accepted:
- **Unsigned byte:** taken from the low eight bits of the input bus.
- **Signed 16-bit word:** the full bus in two's complement.

The loop uses either one integrator or two chained integrators. Both integrators subtract the same feedback word. That word comes from a one-bit digital-to-digital converter, which copies the output bit across every bit of a data word and then inverts the top bit. Internally both formats are therefore handled as signed offset-binary values. This keeps the quantizer threshold at zero.

The integrators carry guard bits above the data width and clamp at their limits instead of wrapping. A synchronous reset clears them and drives the output bit low.

Top module: `dsm_bitstream_mod`

## Requirements
- R1: With `fmt_signed`=0, the input is the unsigned byte `sample_in[7:0]`. The feedback codes are 0x00 (output bit 0) and 0xFF (output bit 1). Over N enabled steps from reset, the count of ones is within 2 of N·u/255.
- R2: With `fmt_signed`=1, the input is `sample_in` as two's complement. The feedback codes are 0x8000 (bit 0) and 0x7FFF (bit 1). Over N enabled steps from reset, the count of ones is within 2 of N·(x+32768)/65535 in first order.
- R3: The feedback word is the output bit copied to every data bit with the top bit inverted. Bit 1 gives the most positive code and bit 0 the most negative code of the selected format.
- R4: With `order2`=0, each enabled step adds (input − feedback of the current output bit) to one integrator. The new output bit is 1 when the updated integrator is ≥ 0, otherwise 0. The bit appears on `bit_out` after the clock edge of that step. The second integrator is held at zero.
- R5: The integrators are 4 guard bits wider than the signed data width and saturate at their limits instead of wrapping. A full-scale input in second order yields at most 4 zeros (max code) or at most 4 ones (min code) in 512 steps.
- R6: With `order2`=1, the first integrator accumulates (input − feedback). The second accumulates (updated first integrator − feedback). The output bit is 1 when the updated second integrator is ≥ 0. For inputs between 25 % and 75 % of range, the count of ones over 1024 steps is within 8 of the ideal count.
- R7: While `en`=0, `bit_out` and both integrators hold. The input is ignored, and the bitstream resumes as if the idle cycles had not occurred.
- R8: `rst`=1 at a clock edge clears both integrators and sets `bit_out` to 0, whatever the value of `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Step enable, one pulse per oversampled bit |
| fmt_signed | input | 1 | 0: unsigned byte in bits [7:0]; 1: signed 16-bit word |
| order2 | input | 1 | 0: first-order loop; 1: second-order loop |
| sample_in | input | 16 | PCM sample, held for one oversampling period |
| bit_out | output | 1 | Registered modulator output bit |

## Verification
On every cycle the assertions check the following:
- The feedback word is one of the two reference codes that matches the current output bit and format.
- The output bit follows the sign of the active integrator.
- The idle second integrator stays at zero in first order.
- Output and state hold while the enable is low.
- Reset clears the output.
- A non-negative integrator cannot turn negative when it adds a non-negative difference, so there is no wraparound.

Only the bench's scenarios can show that the density of ones tracks the input, since that depends on whole sequences. The bench sweeps every unsigned code and a set of signed values against an arithmetic reference, checks second-order averages and rail inputs, and tests that idle cycles are invisible.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef enum logic {
    FMT_UBYTE  = 1'b0,
    FMT_SWORD  = 1'b1
  } dsm_fmt_e;

  typedef enum logic {
    LOOP_FIRST  = 1'b0,
    LOOP_SECOND = 1'b1
  } dsm_loop_e;

  localparam int unsigned NUM_STAGES = 2;
endpackage

// File: rtl/dsm_input_map.sv
module dsm_input_map #(
  parameter int unsigned S_W   = 16,
  parameter int unsigned U_W   = 8,
  parameter int unsigned ACC_W = 20
) (
  input  logic                    fmt_signed,
  input  logic [S_W-1:0]          sample,
  output logic signed [ACC_W-1:0] x_ext
);
  // Offset-binary to signed: invert the top bit of the unsigned byte.
  function automatic logic signed [U_W-1:0] ubyte_to_signed(input logic [U_W-1:0] u);
    return {~u[U_W-1], u[U_W-2:0]};
  endfunction

  logic signed [S_W-1:0] word_s;
  logic signed [U_W-1:0] byte_s;

  always_comb begin
    word_s = sample;
    byte_s = ubyte_to_signed(sample[U_W-1:0]);
    if (fmt_signed == dsm_pkg::FMT_SWORD) x_ext = ACC_W'(word_s);
    else                                  x_ext = ACC_W'(byte_s);
  end
endmodule

// File: rtl/dsm_feedback_ddc.sv
module dsm_feedback_ddc #(
  parameter int unsigned S_W   = 16,
  parameter int unsigned U_W   = 8,
  parameter int unsigned ACC_W = 20
) (
  input  logic                    fmt_signed,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] fb_word
);
  // Replicate the bit over the word, then flip the top bit so that the
  // all-zero and all-one words land on the negative and positive rails.
  logic signed [S_W-1:0] word_fb;
  logic signed [U_W-1:0] byte_fb;

  genvar gi;
  generate
    for (gi = 0; gi < S_W; gi++) begin : g_word
      if (gi == S_W-1) begin : g_top
        assign word_fb[gi] = ~bit_in;
      end else begin : g_rest
        assign word_fb[gi] = bit_in;
      end
    end
    for (gi = 0; gi < U_W; gi++) begin : g_byte
      if (gi == U_W-1) begin : g_top
        assign byte_fb[gi] = ~bit_in;
      end else begin : g_rest
        assign byte_fb[gi] = bit_in;
      end
    end
  endgenerate

  always_comb begin
    if (fmt_signed == dsm_pkg::FMT_SWORD) fb_word = ACC_W'(word_fb);
    else                                  fb_word = ACC_W'(byte_fb);
  end
endmodule

// File: rtl/dsm_sat_integrator.sv
module dsm_sat_integrator #(
  parameter int unsigned ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] add_term,
  input  logic signed [ACC_W-1:0] sub_term,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-1:0] acc_next
);
  localparam int unsigned SUM_W = ACC_W + 2;

  function automatic logic signed [ACC_W-1:0] clip(input logic signed [SUM_W-1:0] v);
    logic signed [SUM_W-1:0] hi_lim;
    logic signed [SUM_W-1:0] lo_lim;
    hi_lim = SUM_W'({1'b0, {(ACC_W-1){1'b1}}});
    lo_lim = -hi_lim - SUM_W'(1);
    if (v > hi_lim)      return {1'b0, {(ACC_W-1){1'b1}}};
    else if (v < lo_lim) return {1'b1, {(ACC_W-1){1'b0}}};
    else                 return v[ACC_W-1:0];
  endfunction

  logic signed [SUM_W-1:0] sum_wide;

  always_comb begin
    sum_wide = SUM_W'(acc_q) + SUM_W'(add_term) - SUM_W'(sub_term);
    acc_next = clip(sum_wide);
  end

  always_ff @(posedge clk) begin
    if (clr)     acc_q <= '0;
    else if (en) acc_q <= acc_next;
  end
endmodule

// File: rtl/dsm_bitstream_mod.sv
module dsm_bitstream_mod #(
  parameter int unsigned S_W   = 16,
  parameter int unsigned U_W   = 8,
  parameter int unsigned GUARD = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           fmt_signed,
  input  logic           order2,
  input  logic [S_W-1:0] sample_in,
  output logic           bit_out
);
  localparam int unsigned ACC_W = S_W + GUARD;
  localparam int unsigned NST   = dsm_pkg::NUM_STAGES;

  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] fb_word;
  logic signed [ACC_W-1:0] stage_in   [NST];
  logic signed [ACC_W-1:0] stage_q    [NST];
  logic signed [ACC_W-1:0] stage_next [NST];
  logic                    bit_q;

  // Named views for the checker.
  logic signed [ACC_W-1:0] acc1_q;
  logic signed [ACC_W-1:0] acc2_q;
  assign acc1_q = stage_q[0];
  assign acc2_q = stage_q[1];

  dsm_input_map #(.S_W(S_W), .U_W(U_W), .ACC_W(ACC_W)) u_map (
    .fmt_signed (fmt_signed),
    .sample     (sample_in),
    .x_ext      (x_ext)
  );

  dsm_feedback_ddc #(.S_W(S_W), .U_W(U_W), .ACC_W(ACC_W)) u_ddc (
    .fmt_signed (fmt_signed),
    .bit_in     (bit_q),
    .fb_word    (fb_word)
  );

  genvar gs;
  generate
    for (gs = 0; gs < NST; gs++) begin : g_stage
      logic stage_clr;
      if (gs == 0) begin : g_first
        assign stage_in[gs] = x_ext;
        assign stage_clr    = rst;
      end else begin : g_later
        assign stage_in[gs] = stage_next[gs-1];
        assign stage_clr    = rst | (order2 == dsm_pkg::LOOP_FIRST);
      end
      dsm_sat_integrator #(.ACC_W(ACC_W)) u_int (
        .clk      (clk),
        .clr      (stage_clr),
        .en       (en),
        .add_term (stage_in[gs]),
        .sub_term (fb_word),
        .acc_q    (stage_q[gs]),
        .acc_next (stage_next[gs])
      );
    end
  endgenerate

  logic quant_in_neg;
  assign quant_in_neg = (order2 == dsm_pkg::LOOP_SECOND) ? stage_next[NST-1][ACC_W-1]
                                                         : stage_next[0][ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst)     bit_q <= 1'b0;
    else if (en) bit_q <= ~quant_in_neg;
  end

  assign bit_out = bit_q;
endmodule

// File: rtl/dsm_bitstream_mod_checker.sv
module dsm_bitstream_mod_checker #(
  parameter int unsigned ACC_W = 20
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic                    fmt_signed,
  input logic                    order2,
  input logic                    bit_out,
  input logic signed [ACC_W-1:0] fb_word,
  input logic signed [ACC_W-1:0] x_ext,
  input logic signed [ACC_W-1:0] acc1_q,
  input logic signed [ACC_W-1:0] acc2_q
);
  localparam logic signed [ACC_W-1:0] W_HI = ACC_W'(32767);
  localparam logic signed [ACC_W-1:0] W_LO = -ACC_W'(32768);
  localparam logic signed [ACC_W-1:0] B_HI = ACC_W'(127);
  localparam logic signed [ACC_W-1:0] B_LO = -ACC_W'(128);

  p_ddc_level_r3: assert property (@(posedge clk) disable iff (rst)
    fb_word == (fmt_signed ? (bit_out ? W_HI : W_LO) : (bit_out ? B_HI : B_LO)));

  p_first_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !order2) |=> (bit_out == !acc1_q[ACC_W-1]));

  p_stage2_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !order2 |=> (acc2_q == '0));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !acc1_q[ACC_W-1] && (x_ext >= fb_word)) |=> !acc1_q[ACC_W-1]);

  p_second_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (en && order2 && $past(order2)) |=> (bit_out == !acc2_q[ACC_W-1]));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(bit_out) && $stable(acc1_q)));

  p_reset_low_r8: assert property (@(posedge clk)
    rst |=> !bit_out);
endmodule

bind dsm_bitstream_mod dsm_bitstream_mod_checker #(.ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .fmt_signed (fmt_signed),
  .order2     (order2),
  .bit_out    (bit_out),
  .fb_word    (fb_word),
  .x_ext      (x_ext),
  .acc1_q     (acc1_q),
  .acc2_q     (acc2_q)
);

// File: tb/dsm_bitstream_mod_test.sv
module dsm_bitstream_mod_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic        fmt_signed = 1'b0;
  logic        order2 = 1'b0;
  logic [15:0] sample_in = '0;
  logic        bit_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // Reference loop state (first order), kept as plain integers.
  longint ref_acc;
  logic   ref_bit;

  dsm_bitstream_mod uut (
    .clk(clk), .rst(rst), .en(en), .fmt_signed(fmt_signed),
    .order2(order2), .sample_in(sample_in), .bit_out(bit_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp, input longint tol);
    longint d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  function automatic longint rail_lo(input logic fs);
    return fs ? -64'sd32768 : -64'sd128;
  endfunction
  function automatic longint rail_hi(input logic fs);
    return fs ? 64'sd32767 : 64'sd127;
  endfunction
  function automatic longint as_value(input logic fs, input logic [15:0] v);
    if (fs) return longint'($signed(v));
    return longint'(v[7:0]) - 128;
  endfunction

  task automatic do_reset(input string req);
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(req, bit_out, 0, 0);
    rst = 1'b0;
    ref_acc = 0; ref_bit = 1'b0;
  endtask

  // One enabled step with the reference advanced alongside; returns mismatch.
  task automatic ref_step(input logic fs, input logic [15:0] v, output bit bad);
    longint fb;
    en = 1'b1; fmt_signed = fs; sample_in = v;
    fb = ref_bit ? rail_hi(fs) : rail_lo(fs);
    ref_acc = ref_acc + as_value(fs, v) - fb;
    ref_bit = (ref_acc >= 0);
    @(posedge clk);
    @(negedge clk);
    bad = (bit_out !== ref_bit);
  endtask

  task automatic exact_run(input string req_seq, input string req_avg,
                           input logic fs, input logic [15:0] v, input int n);
    int ones = 0;
    int first_bad = -1;
    bit bad;
    longint span;
    do_reset("R8");
    order2 = 1'b0;
    for (int k = 0; k < n; k++) begin
      ref_step(fs, v, bad);
      if (bit_out) ones++;
      if (bad && first_bad < 0) first_bad = k;
    end
    en = 1'b0;
    check(req_seq, first_bad, -1, 0);
    span = rail_hi(fs) - rail_lo(fs);
    check(req_avg, ones, (longint'(n) * (as_value(fs, v) - rail_lo(fs)) + span/2) / span, 2);
  endtask

  task automatic count_run(input string req, input logic fs, input logic o2,
                           input logic [15:0] v, input int n, output int ones);
    do_reset("R8");
    ones = 0;
    @(negedge clk);
    order2 = o2; fmt_signed = fs; sample_in = v;
    for (int k = 0; k < n; k++) begin
      en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (bit_out) ones++;
    end
    en = 1'b0;
    if (req.len() == 0) ones = ones;
  endtask

  initial begin
    int ones;
    longint span;
    bit bad;
    logic [15:0] sv [8] = '{16'h8000, 16'h8ACF, 16'hB1E0, 16'hFFFF,
                            16'h0000, 16'h0001, 16'h3039, 16'h7FFF};
    logic [15:0] mid [6] = '{16'h0040, 16'h0080, 16'h00C0,
                             16'hC000, 16'h0000, 16'h4000};
    logic        midf [6] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

    // R8: reset state
    do_reset("R8");

    // R1, R4: every unsigned code, exact sequence and average (R3 at the rails)
    for (int u = 0; u < 256; u++) begin
      if (u == 0 || u == 255) exact_run("R3", "R3", 1'b0, 16'(u), 64);
      else                    exact_run("R4", "R1", 1'b0, 16'(u), 64);
    end

    // R2: signed values, first order
    foreach (sv[i]) exact_run("R4", "R2", 1'b1, sv[i], 512);

    // R6: second order, mid-range inputs
    foreach (mid[i]) begin
      count_run("R6", midf[i], 1'b1, mid[i], 1024, ones);
      span = rail_hi(midf[i]) - rail_lo(midf[i]);
      check("R6", ones,
            (64'sd1024 * (as_value(midf[i], mid[i]) - rail_lo(midf[i])) + span/2) / span, 8);
    end

    // R5: full scale in second order must not wrap
    count_run("R5", 1'b1, 1'b1, 16'h7FFF, 512, ones);
    check("R5", ones, 512, 4);
    count_run("R5", 1'b1, 1'b1, 16'h8000, 512, ones);
    check("R5", ones, 0, 4);
    count_run("R5", 1'b0, 1'b1, 16'h00FF, 512, ones);
    check("R5", ones, 512, 4);

    // R7: idle cycles hold output and state; input changes ignored
    do_reset("R8");
    order2 = 1'b0;
    for (int k = 0; k < 13; k++) begin
      ref_step(1'b1, 16'h2222, bad);
      check("R7", bad, 0, 0);
    end
    begin
      logic held;
      held = bit_out;
      en = 1'b0;
      for (int k = 0; k < 16; k++) begin
        sample_in = 16'(k * 4099);
        fmt_signed = k[0];
        @(posedge clk);
        @(negedge clk);
        check("R7", bit_out, held, 0);
      end
    end
    for (int k = 0; k < 40; k++) begin
      ref_step(1'b1, 16'h2222, bad);
      check("R7", bad, 0, 0);
    end

    // R8: reset while enabled clears output mid-stream
    @(negedge clk);
    rst = 1'b1; en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8", bit_out, 0, 0);
    rst = 1'b0; en = 1'b0;
    ref_acc = 0; ref_bit = 1'b0;
    for (int k = 0; k < 20; k++) begin
      ref_step(1'b0, 16'h0033, bad);
      check("R8", bad, 0, 0);
    end
    en = 1'b0;

    finish_run();
  end
endmodule